// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the operand bytes of an 8-bit accumulator processor into a 16-bit effective address. A sequencer pulses `start` with the addressing-mode code, the program counter (already advanced past the operand bytes), both index registers and up to two operand bytes. The unit captures them and, when done, reports either a 16-bit address or a flag saying the operand is supplied directly (immediate, accumulator or implied).

Modes that go through a pointer read its two bytes over a read port with one cycle of latency, one request per cycle. Indexed-indirect and indirect-indexed pointers never leave page zero. The plain indirect pointer is a full 16-bit address and carries into the next page. Relative offsets are treated as signed bytes.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done`, `memRdEn`, `isDirect` are low and `effAddr` is 0x0000.
- R2: Mode codes 0 (implied), 1 (accumulator) and 2 (immediate) raise `done` one cycle after `start`, with `isDirect` high, `effAddr` 0x0000 and no read request.
- R3: Mode 3 (zero page) yields {0x00, opLo}. Mode 6 (absolute) yields {opHi, opLo}. Both are done one cycle after `start`.
- R4: Modes 4 (zero page + X) and 5 (zero page + Y) add the index modulo 256, so the high byte is always 0x00.
- R5: Modes 7 (absolute + X) and 8 (absolute + Y) add the index to {opHi, opLo} modulo 65536.
- R6: Mode 9 (relative) yields pc + opLo with opLo taken as two's complement. An offset of 0x80 or more moves backward (pc − (256 − opLo)), modulo 65536.
- R7: Mode 10 (indexed indirect) reads the pointer low byte at (opLo + X) mod 256 and the high byte at (opLo + X + 1) mod 256, both in page zero. The result is that pointer.
- R8: Mode 11 (indirect indexed) reads the pointer at opLo and at (opLo + 1) mod 256 in page zero. The result is pointer + Y modulo 65536.
- R9: Mode 12 (indirect) reads the pointer at {opHi, opLo} and at {opHi, opLo} + 1 with a 16-bit carry. Pointer 0x00FF holding 0x00 then 0x6C gives 0x6C00.
- R10: Pointer modes request the low byte in the first cycle after `start` and the high byte in the second. `done` rises in the fourth cycle, when no read is requested. `done` lasts one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (honoured when idle) |
| mode | input | 4 | Addressing-mode code |
| pc | input | 16 | Program counter past the operand |
| xIdx | input | 8 | X index |
| yIdx | input | 8 | Y index |
| opLo | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte |
| memRdData | input | 8 | Read data, valid the cycle after a request |
| memRdEn | output | 1 | Read request |
| memRdAddr | output | 16 | Read address |
| done | output | 1 | Result valid pulse |
| effAddr | output | 16 | Effective address (held until next result) |
| isDirect | output | 1 | Operand supplied without an address |

## Verification
Direct and arithmetic modes deliver their result one cycle after `start`. Pointer modes show their two read requests in cycles one and two and deliver the result in cycle four. The bench drives `start` on a falling edge and then samples on each following falling edge. It logs every read request with the cycle it appeared in, and compares the cycle in which `done` appears with the latency due for the mode. It checks the address and direct flag only at that point.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_IMP = 4'd0, AM_ACC = 4'd1, AM_IMM = 4'd2, AM_ZP = 4'd3,
    AM_ZPX = 4'd4, AM_ZPY = 4'd5, AM_ABS = 4'd6, AM_ABSX = 4'd7,
    AM_ABSY = 4'd8, AM_REL = 4'd9, AM_INDX = 4'd10, AM_INDY = 4'd11,
    AM_IND = 4'd12
  } addrMode_t;

  typedef struct packed {
    logic latchIn;
    logic reqLo;
    logic reqHi;
    logic capLo;
    logic finish;
  } eagStrobe_t;

  function automatic logic usesPointer(input logic [3:0] m);
    return (m == AM_INDX) || (m == AM_INDY) || (m == AM_IND);
  endfunction
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  output eagStrobe_t strobe,
  output logic       idle
);
  typedef enum logic [1:0] {S_IDLE, S_RDLO, S_RDHI, S_GETHI} ctrlState_t;
  ctrlState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe = '0;
    case (state)
      S_IDLE: if (start) begin
        strobe.latchIn = 1'b1;
        if (usesPointer(mode)) nextState = S_RDLO;
        else strobe.finish = 1'b1;
      end
      S_RDLO: begin
        strobe.reqLo = 1'b1;
        nextState = S_RDHI;
      end
      S_RDHI: begin
        strobe.reqHi = 1'b1;
        strobe.capLo = 1'b1;
        nextState = S_GETHI;
      end
      default: begin
        strobe.finish = 1'b1;
        nextState = S_IDLE;
      end
    endcase
  end

  assign idle = (state == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eagStrobe_t        strobe,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] xIdx,
  input  logic [DATA_W-1:0] yIdx,
  input  logic [DATA_W-1:0] opLo,
  input  logic [DATA_W-1:0] opHi,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              isDirect,
  output logic [3:0]        modeHeld
);
  localparam logic [DATA_W-1:0] PAGE_ZERO = '0;

  logic [3:0]        modeQ, m;
  logic [ADDR_W-1:0] pcQ, p;
  logic [DATA_W-1:0] xQ, yQ, loQ, hiQ, ptrLoQ, x, y, l, h;
  logic [ADDR_W-1:0] opWord, ptrWord, loAddr, hiAddr, result;
  logic [DATA_W-1:0] zpSumX, zpSumY, zpIdxPtr;

  assign m = strobe.latchIn ? mode : modeQ;
  assign p = strobe.latchIn ? pc   : pcQ;
  assign x = strobe.latchIn ? xIdx : xQ;
  assign y = strobe.latchIn ? yIdx : yQ;
  assign l = strobe.latchIn ? opLo : loQ;
  assign h = strobe.latchIn ? opHi : hiQ;

  assign opWord   = {h, l};
  assign zpSumX   = l + x;
  assign zpSumY   = l + y;
  assign zpIdxPtr = (m == AM_INDX) ? zpSumX : l;
  assign ptrWord  = {memRdData, ptrLoQ};

  always_comb begin
    if (m == AM_IND) begin
      loAddr = opWord;
      hiAddr = opWord + ADDR_W'(1);
    end else begin
      loAddr = {PAGE_ZERO, zpIdxPtr};
      hiAddr = {PAGE_ZERO, DATA_W'(zpIdxPtr + DATA_W'(1))};
    end
  end

  assign memRdEn   = strobe.reqLo | strobe.reqHi;
  assign memRdAddr = strobe.reqHi ? hiAddr : loAddr;

  always_comb begin
    case (m)
      AM_ZP:   result = {PAGE_ZERO, l};
      AM_ZPX:  result = {PAGE_ZERO, zpSumX};
      AM_ZPY:  result = {PAGE_ZERO, zpSumY};
      AM_ABS:  result = opWord;
      AM_ABSX: result = opWord + ADDR_W'(x);
      AM_ABSY: result = opWord + ADDR_W'(y);
      AM_REL:  result = p + {{DATA_W{l[DATA_W-1]}}, l};
      AM_INDX: result = ptrWord;
      AM_INDY: result = ptrWord + ADDR_W'(y);
      AM_IND:  result = ptrWord;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0; pcQ <= '0; xQ <= '0; yQ <= '0; loQ <= '0; hiQ <= '0;
      ptrLoQ <= '0; done <= 1'b0; effAddr <= '0; isDirect <= 1'b0;
    end else begin
      if (strobe.latchIn) begin
        modeQ <= mode; pcQ <= pc; xQ <= xIdx; yQ <= yIdx;
        loQ <= opLo; hiQ <= opHi;
      end
      if (strobe.capLo) ptrLoQ <= memRdData;
      done <= strobe.finish;
      if (strobe.finish) begin
        effAddr  <= result;
        isDirect <= (m <= AM_IMM);
      end
    end
  end

  assign modeHeld = modeQ;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] xIdx,
  input  logic [DATA_W-1:0] yIdx,
  input  logic [DATA_W-1:0] opLo,
  input  logic [DATA_W-1:0] opHi,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              isDirect
);
  eagStrobe_t strobe;
  logic       ctrlIdle;
  logic [3:0] modeHeld;

  eag_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .strobe(strobe), .idle(ctrlIdle)
  );

  eag_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .pc(pc),
    .xIdx(xIdx), .yIdx(yIdx), .opLo(opLo), .opHi(opHi),
    .memRdData(memRdData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .done(done), .effAddr(effAddr), .isDirect(isDirect), .modeHeld(modeHeld)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker
  import eag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [3:0]        mode,
  input logic              ctrlIdle,
  input logic [3:0]        modeHeld,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              done,
  input logic              isDirect
);
  localparam int HALF_W = ADDR_W / 2;

  AST_DIRECT_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    start && ctrlIdle && (mode <= AM_IMM) |=> done && isDirect && !memRdEn); // R2

  AST_PTR_FIRST_REQ: assert property (@(posedge clk) disable iff (!rstN)
    start && ctrlIdle && usesPointer(mode) |=> memRdEn && !done); // R10

  AST_PTR_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRdEn) |=> done); // R10

  AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRdEn); // R10

  AST_ZP_PTR_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && $past(memRdEn) && (modeHeld != AM_IND) |->
      (memRdAddr[ADDR_W-1:HALF_W] == '0) &&
      (memRdAddr[HALF_W-1:0] == HALF_W'($past(memRdAddr[HALF_W-1:0]) + 1'b1))); // R7 R8

  AST_IND_PTR_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && $past(memRdEn) && (modeHeld == AM_IND) |->
      memRdAddr == ADDR_W'($past(memRdAddr) + 1'b1)); // R9
endmodule

bind ea_gen eag_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .mode(mode), .ctrlIdle(ctrlIdle),
  .modeHeld(modeHeld), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
  .done(done), .isDirect(isDirect)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  xIdx = '0, yIdx = '0, opLo = '0, opHi = '0;
  logic [7:0]  memRdData = '0;
  logic        memRdEn, done, isDirect;
  logic [15:0] memRdAddr, effAddr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pc(pc),
    .xIdx(xIdx), .yIdx(yIdx), .opLo(opLo), .opHi(opHi),
    .memRdData(memRdData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .done(done), .effAddr(effAddr), .isDirect(isDirect)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    if (a == 16'h00FF) return 8'h00;
    if (a == 16'h0100) return 8'h6C;
    return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memFn(memRdAddr);

  function automatic string reqTag(input logic [3:0] m);
    case (m)
      4'd0, 4'd1, 4'd2: return "R2";
      4'd3, 4'd6:       return "R3";
      4'd4, 4'd5:       return "R4";
      4'd7, 4'd8:       return "R5";
      4'd9:             return "R6";
      4'd10:            return "R7";
      4'd11:            return "R8";
      default:          return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic expectOf(input logic [3:0] m, input logic [15:0] p,
      input logic [7:0] x, input logic [7:0] y, input logic [7:0] l,
      input logic [7:0] h, output logic [15:0] ea, output logic dir,
      output int nRd, output logic [15:0] a0, output logic [15:0] a1);
    logic [15:0] ptr;
    dir = 1'b0; nRd = 0; a0 = '0; a1 = '0; ea = '0;
    case (m)
      4'd0, 4'd1, 4'd2: dir = 1'b1;
      4'd3:  ea = {8'h00, l};
      4'd4:  ea = {8'h00, 8'(l + x)};
      4'd5:  ea = {8'h00, 8'(l + y)};
      4'd6:  ea = {h, l};
      4'd7:  ea = 16'({h, l} + {8'h00, x});
      4'd8:  ea = 16'({h, l} + {8'h00, y});
      4'd9:  ea = (l >= 8'h80) ? 16'(p - (16'd256 - {8'h00, l}))
                               : 16'(p + {8'h00, l});
      4'd10: begin a0 = {8'h00, 8'(l + x)}; a1 = {8'h00, 8'(l + x + 8'd1)}; end
      4'd11: begin a0 = {8'h00, l}; a1 = {8'h00, 8'(l + 8'd1)}; end
      default: begin a0 = {h, l}; a1 = 16'({h, l} + 16'd1); end
    endcase
    if (m >= 4'd10) begin
      nRd = 2;
      ptr = {memFn(a1), memFn(a0)};
      ea = (m == 4'd11) ? 16'(ptr + {8'h00, y}) : ptr;
    end
  endtask

  task automatic runOp(input logic [3:0] m, input logic [15:0] p,
      input logic [7:0] x, input logic [7:0] y, input logic [7:0] l,
      input logic [7:0] h);
    logic [15:0] ea, a0, a1;
    logic [15:0] seen [2];
    int seenCyc [2];
    logic dir;
    int nRd, cyc, reads;
    string tag;
    expectOf(m, p, x, y, l, h, ea, dir, nRd, a0, a1);
    tag = reqTag(m);
    @(negedge clk);
    mode = m; pc = p; xIdx = x; yIdx = y; opLo = l; opHi = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; reads = 0;
    while (!done && cyc < 8) begin
      if (memRdEn) begin
        if (reads < 2) begin seen[reads] = memRdAddr; seenCyc[reads] = cyc; end
        reads++;
      end
      @(negedge clk);
      cyc++;
    end
    check(nRd == 0 ? tag : "R10", "done latency", cyc, (nRd == 0) ? 1 : 4);
    check("R10", "read requests during done", {31'd0, memRdEn}, 0);
    check(tag, "read count", reads, nRd);
    check(tag, "effective address", {16'd0, effAddr}, {16'd0, ea});
    check(tag, "direct flag", {31'd0, isDirect}, {31'd0, dir});
    if (nRd == 2 && reads == 2) begin
      check(tag, "low pointer address", {16'd0, seen[0]}, {16'd0, a0});
      check(tag, "high pointer address", {16'd0, seen[1]}, {16'd0, a1});
      check("R10", "low request cycle", seenCyc[0], 1);
      check("R10", "high request cycle", seenCyc[1], 2);
    end
    @(negedge clk);
    check("R10", "done lasts one cycle", {31'd0, done}, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done after reset", {31'd0, done}, 0);
    check("R1", "read enable after reset", {31'd0, memRdEn}, 0);
    check("R1", "address after reset", {16'd0, effAddr}, 0);
    check("R1", "direct after reset", {31'd0, isDirect}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runOp(4'd2, 16'h1234, 8'h11, 8'h22, 8'h33, 8'h44);   // R2 immediate
    runOp(4'd1, 16'h0000, 8'h00, 8'h00, 8'hFF, 8'hFF);   // R2 accumulator
    runOp(4'd0, 16'hFFFF, 8'h01, 8'h02, 8'h03, 8'h04);   // R2 implied
    runOp(4'd3, 16'h0200, 8'h05, 8'h06, 8'h9A, 8'hBC);   // R3 zero page
    runOp(4'd6, 16'h0200, 8'h05, 8'h06, 8'hCD, 8'hAB);   // R3 absolute
    runOp(4'd4, 16'h0000, 8'h20, 8'h00, 8'hF0, 8'h77);   // R4 wrap to 0x10
    runOp(4'd5, 16'h0000, 8'h00, 8'hFF, 8'h01, 8'h77);   // R4 wrap to 0x00
    runOp(4'd7, 16'h0000, 8'h02, 8'h00, 8'hFF, 8'hFF);   // R5 wrap to 0x0001
    runOp(4'd8, 16'h0000, 8'h00, 8'h10, 8'hF8, 8'h12);   // R5 page carry
    runOp(4'd9, 16'h0052, 8'h00, 8'h00, 8'hFA, 8'h00);   // R6 back 6 -> 0x004C
    runOp(4'd9, 16'h0010, 8'h00, 8'h00, 8'h7F, 8'h00);   // R6 largest forward
    runOp(4'd9, 16'h0001, 8'h00, 8'h00, 8'h80, 8'h00);   // R6 wrap below zero
    runOp(4'd10, 16'h0000, 8'h00, 8'h00, 8'hFF, 8'h00);  // R7 pointer wraps in page zero
    runOp(4'd10, 16'h0000, 8'h80, 8'h00, 8'h90, 8'h33);  // R7 index wrap
    runOp(4'd11, 16'h0000, 8'h00, 8'hFF, 8'hFF, 8'h00);  // R8 pointer wrap plus Y
    runOp(4'd11, 16'h0000, 8'h00, 8'h07, 8'h40, 8'h00);  // R8
    runOp(4'd12, 16'h0000, 8'h00, 8'h00, 8'hFF, 8'h00);  // R9 resolves to 0x6C00
    check("R9", "indirect through 0x00FF", {16'd0, effAddr}, 32'h6C00);

    for (int i = 0; i < 300; i++) begin
      runOp(4'($urandom % 13), 16'($urandom), 8'($urandom), 8'($urandom),
            8'($urandom), 8'($urandom));
    end
    finishRun();
  end
endmodule